// File: doc/BRIEF.md
# Ring network controller: command, flag and interrupt core

This block is the command, status and interrupt core of a token-ring network controller that keeps its frames in a small set of buffer pages. The host sees a few byte-wide registers on a simple read/write strobe bus. A write of a command byte starts a transmission from a page, prepares reception into a page, or sets and clears status flags. The link side reports transmit acknowledge, transmit completion and frame arrival back to the core. Bus accesses and link events are turned into a single interrupt pulse.

The buffer memory and the physical link are outside the block. A transmission leaves as a one-cycle `tx_start` pulse with its page and length mode. An accepted frame leaves as a one-cycle `rx_store` pulse with its destination page. After every reset the core asks the buffer to seed its first two bytes with a known check byte and the node identifier.

Top module: `ringnet_ctrl_core`

## Requirements
- R1: After hard reset the status register reads 0x95, the interrupt mask is 0, the setup register reads 0x1C and the node register reads NODE_RESET. In the first cycle after reset `buf_init` is high with `buf_init_word` = {node, 0xD1}. Status bits: 0 transmitter free (TF), 1 transmit acknowledged (TK), 2 ring reconfigured (RC), 3 test (always 0), 4 power-up (PU), 7 receiver blocked (RB).
- R2: Register offsets: 0 reads status and writes the mask; 1 reads diagnostics and writes a command; 2 is the setup register (read/write); 5 is the node register (read/write). Offsets 3, 4, 6, 7 and 12 to 15 read 0.
- R3: A command carries its opcode in bits 2:0 and its page in bits 4:3. Opcode 3 (start transmit) clears TF and TK, and in the next cycle pulses `tx_start` with `tx_page` and `tx_long`.
- R4: `tx_ack` sets TK and `tx_done` sets TF. Opcode 1 (cancel transmit) sets TF.
- R5: Opcode 5 (setup) latches bit 3 as the long-frame flag, which is carried on `tx_long` by later transmits.
- R6: Opcode 4 (arm receive) records the page and the broadcast-accept flag (bit 7) and clears RB. `rx_ready` is the inverse of RB.
- R7: A frame on `rx_valid` is taken only when RB is clear, and only when `rx_dest` is non-zero or broadcast is accepted. A taken frame sets RB and pulses `rx_store` with `rx_page` in the next cycle. Any other frame leaves the state unchanged.
- R8: Opcode 2 (block receive) sets RB and never raises the interrupt.
- R9: Opcode 6 clears PU when bit 3 is set and clears RC when bit 4 is set. Opcodes 0 and 7 change nothing.
- R10: Only TF, RC and RB can interrupt. `irq` is high for one cycle, one cycle after a bit of status AND mask AND those bits first becomes 1. A mask write counts as a cause.
- R11: Any read or write at offsets 8 to 11 is a soft reset. It restores the R1 status, mask and setup values, clears the long-frame and broadcast flags, keeps the node value, and pulses `buf_init` in the next cycle. A read there returns 0.
- R12: `diag_set` bits accumulate into the diagnostic register. A read of offset 1 returns the value and clears it, keeping any bits set in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low hard reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | ADDR_W (4) | Register offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from `bus_addr` |
| tx_start | output | 1 | Transmit request pulse |
| tx_page | output | PAGE_W (2) | Page to transmit |
| tx_long | output | 1 | Long-frame mode for this transmit |
| tx_ack | input | 1 | Link: frame acknowledged |
| tx_done | input | 1 | Link: transmit finished |
| rx_valid | input | 1 | Link: frame arriving |
| rx_dest | input | 8 | Destination node of the arriving frame |
| rx_ready | output | 1 | Reception armed |
| rx_store | output | 1 | Pulse: store the accepted frame |
| rx_page | output | PAGE_W (2) | Page for the accepted frame |
| diag_set | input | 8 | Diagnostic event bits |
| buf_init | output | 1 | Pulse: seed the buffer's first two bytes |
| buf_init_word | output | 16 | Seed value {node, 0xD1} |
| irq | output | 1 | Interrupt pulse |

## Verification
The assertions assume that a command write does not coincide with a link event on the same flag: the transmit-clear check excludes cycles with `tx_ack` or `tx_done`, and the diagnostic-clear check excludes cycles with `diag_set` active. They also assume that the strobes and link pulses are single-cycle and well formed. The stimulus meets these assumptions by construction. It issues every bus access and every link pulse on its own cycle, never two at once, and it holds `diag_set` at zero while reading the diagnostic register. Interrupt expectations are queued per stimulus, so an extra pulse, such as one after a block-receive command, is reported as well as a missing one.

// File: rtl/ringnet_pkg.sv
`timescale 1ns/1ps
package ringnet_pkg;
   // status flag positions
   localparam int ST_TF  = 0;
   localparam int ST_TK  = 1;
   localparam int ST_RC  = 2;
   localparam int ST_TST = 3;
   localparam int ST_PU  = 4;
   localparam int ST_RB  = 7;

   localparam logic [7:0] ST_RESET = 8'h95;   // PU | RC | RB | TF
   localparam logic [7:0] IRQ_SRC  = 8'h85;   // TF | RC | RB

   localparam logic [3:0] OFF_STAT = 4'h0;
   localparam logic [3:0] OFF_CMD  = 4'h1;
   localparam logic [3:0] OFF_CFG  = 4'h2;
   localparam logic [3:0] OFF_NODE = 4'h5;

   typedef enum logic [2:0] {
      OP_NOP    = 3'd0,
      OP_TX_OFF = 3'd1,
      OP_RX_OFF = 3'd2,
      OP_TX_ON  = 3'd3,
      OP_RX_ON  = 3'd4,
      OP_SETUP  = 3'd5,
      OP_CLR    = 3'd6,
      OP_RSVD   = 3'd7
   } opcode_e;

   typedef struct packed {
      logic       tx_on;
      logic       tx_off;
      logic       rx_on;
      logic       rx_off;
      logic       setup;
      logic       clr;
      logic       mask_we;
      logic       cfg_we;
      logic       node_we;
      logic       diag_rd;
      logic       soft_rst;
      logic [7:0] raw;
   } ctl_t;
endpackage

// File: rtl/ringnet_bus_decode.sv
`timescale 1ns/1ps
module ringnet_bus_decode
   import ringnet_pkg::*;
#(
   parameter int ADDR_W = 4
) (
   input  logic              bus_wr,
   input  logic              bus_rd,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [7:0]        bus_wdata,
   output ctl_t              ctl
);
   logic       in_window;
   logic [3:0] off;
   opcode_e    op;

   assign off = bus_addr[3:0];

   generate
      if (ADDR_W > 4) begin : g_wide
         assign in_window = ~|bus_addr[ADDR_W-1:4];
      end else begin : g_narrow
         assign in_window = 1'b1;
      end
   endgenerate

   assign op = opcode_e'(bus_wdata[2:0]);

   always_comb begin
      ctl     = '0;
      ctl.raw = bus_wdata;
      if (in_window) begin
         ctl.soft_rst = (bus_wr | bus_rd) & (off[3:2] == 2'b10);
         ctl.diag_rd  = bus_rd & (off == OFF_CMD);
         ctl.mask_we  = bus_wr & (off == OFF_STAT);
         ctl.cfg_we   = bus_wr & (off == OFF_CFG);
         ctl.node_we  = bus_wr & (off == OFF_NODE);
         if (bus_wr && off == OFF_CMD) begin
            unique case (op)
               OP_TX_OFF: ctl.tx_off = 1'b1;
               OP_RX_OFF: ctl.rx_off = 1'b1;
               OP_TX_ON:  ctl.tx_on  = 1'b1;
               OP_RX_ON:  ctl.rx_on  = 1'b1;
               OP_SETUP:  ctl.setup  = 1'b1;
               OP_CLR:    ctl.clr    = 1'b1;
               default:   ;
            endcase
         end
      end
   end
endmodule

// File: rtl/ringnet_flag_bank.sv
`timescale 1ns/1ps
module ringnet_flag_bank
   import ringnet_pkg::*;
#(
   parameter int         PAGE_W     = 2,
   parameter logic [7:0] NODE_RESET = 8'h01,
   parameter logic [7:0] CFG_RESET  = 8'h1C
) (
   input  logic              clk,
   input  logic              rst_n,
   input  ctl_t              ctl,
   input  logic              tx_ack,
   input  logic              tx_done,
   input  logic              rx_valid,
   input  logic [7:0]        rx_dest,
   input  logic [7:0]        diag_set,
   output logic [7:0]        status_q,
   output logic [7:0]        mask_q,
   output logic [7:0]        cfg_q,
   output logic [7:0]        node_q,
   output logic [7:0]        diag_q,
   output logic              bcast_q,
   output logic              quiet_q,
   output logic              seed_q,
   output logic              tx_start_q,
   output logic [PAGE_W-1:0] tx_page_q,
   output logic              tx_long_q,
   output logic              rx_store_q,
   output logic [PAGE_W-1:0] store_page_q
);
   logic [7:0]        status_nxt;
   logic [PAGE_W-1:0] arm_page_q;
   logic              long_q;
   logic              rx_take;
   logic [PAGE_W-1:0] cmd_page;

   assign cmd_page = ctl.raw[3 +: PAGE_W];
   assign rx_take  = rx_valid & ~status_q[ST_RB] & ((|rx_dest) | bcast_q);

   always_comb begin
      status_nxt = status_q;
      if (ctl.tx_on) begin
         status_nxt[ST_TF] = 1'b0;
         status_nxt[ST_TK] = 1'b0;
      end
      if (ctl.tx_off) status_nxt[ST_TF] = 1'b1;
      if (ctl.rx_on)  status_nxt[ST_RB] = 1'b0;
      if (ctl.rx_off) status_nxt[ST_RB] = 1'b1;
      if (ctl.clr) begin
         if (ctl.raw[3]) status_nxt[ST_PU] = 1'b0;
         if (ctl.raw[4]) status_nxt[ST_RC] = 1'b0;
      end
      // link events win over a clearing command in the same cycle
      if (tx_ack)  status_nxt[ST_TK] = 1'b1;
      if (tx_done) status_nxt[ST_TF] = 1'b1;
      if (rx_take) status_nxt[ST_RB] = 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         status_q     <= ST_RESET;
         mask_q       <= '0;
         cfg_q        <= CFG_RESET;
         node_q       <= NODE_RESET;
         diag_q       <= '0;
         bcast_q      <= 1'b0;
         long_q       <= 1'b0;
         arm_page_q   <= '0;
         quiet_q      <= 1'b1;
         seed_q       <= 1'b1;
         tx_start_q   <= 1'b0;
         tx_page_q    <= '0;
         tx_long_q    <= 1'b0;
         rx_store_q   <= 1'b0;
         store_page_q <= '0;
      end else begin
         tx_start_q <= 1'b0;
         rx_store_q <= 1'b0;
         seed_q     <= 1'b0;
         quiet_q    <= 1'b0;
         diag_q     <= (ctl.diag_rd ? 8'h00 : diag_q) | diag_set;
         if (ctl.node_we) node_q <= ctl.raw;
         if (ctl.soft_rst) begin
            status_q <= ST_RESET;
            mask_q   <= '0;
            cfg_q    <= CFG_RESET;
            diag_q   <= '0;
            bcast_q  <= 1'b0;
            long_q   <= 1'b0;
            quiet_q  <= 1'b1;
            seed_q   <= 1'b1;
         end else begin
            status_q <= status_nxt;
            quiet_q  <= ctl.rx_off;
            if (ctl.mask_we) mask_q <= ctl.raw;
            if (ctl.cfg_we)  cfg_q  <= ctl.raw;
            if (ctl.setup)   long_q <= ctl.raw[3];
            if (ctl.rx_on) begin
               arm_page_q <= cmd_page;
               bcast_q    <= ctl.raw[7];
            end
            if (ctl.tx_on) begin
               tx_start_q <= 1'b1;
               tx_page_q  <= cmd_page;
               tx_long_q  <= long_q;
            end
            if (rx_take) begin
               rx_store_q   <= 1'b1;
               store_page_q <= arm_page_q;
            end
         end
      end
   end
endmodule

// File: rtl/ringnet_irq_edge.sv
`timescale 1ns/1ps
module ringnet_irq_edge #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] cause,
   input  logic         quiet,
   output logic         irq
);
   logic [W-1:0] seen_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         seen_q <= '0;
         irq    <= 1'b0;
      end else begin
         seen_q <= cause;
         irq    <= ~quiet & (|(cause & ~seen_q));
      end
   end
endmodule

// File: rtl/ringnet_ctrl_core.sv
`timescale 1ns/1ps
module ringnet_ctrl_core
   import ringnet_pkg::*;
#(
   parameter int         ADDR_W     = 4,
   parameter int         PAGES      = 4,
   parameter logic [7:0] NODE_RESET = 8'h01,
   parameter logic [7:0] CFG_RESET  = 8'h1C,
   parameter logic [7:0] MAGIC      = 8'hD1,
   localparam int        PAGE_W     = (PAGES > 1) ? $clog2(PAGES) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic              bus_rd,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [7:0]        bus_wdata,
   output logic [7:0]        bus_rdata,
   output logic              tx_start,
   output logic [PAGE_W-1:0] tx_page,
   output logic              tx_long,
   input  logic              tx_ack,
   input  logic              tx_done,
   input  logic              rx_valid,
   input  logic [7:0]        rx_dest,
   output logic              rx_ready,
   output logic              rx_store,
   output logic [PAGE_W-1:0] rx_page,
   input  logic [7:0]        diag_set,
   output logic              buf_init,
   output logic [15:0]       buf_init_word,
   output logic              irq
);
   generate
      if (ADDR_W < 4) begin : g_bad_addr
         initial $fatal(1, "ADDR_W must cover 16 register offsets");
      end
      if (PAGES < 2 || PAGES > 4 || (PAGES & (PAGES - 1)) != 0) begin : g_bad_pages
         initial $fatal(1, "PAGES must be 2 or 4 to fit the command page field");
      end
   endgenerate

   ctl_t       ctl;
   logic [7:0] status_w, mask_w, cfg_w, node_w, diag_w;
   logic       bcast_w, quiet_w, seed_w;

   ringnet_bus_decode #(.ADDR_W(ADDR_W)) u_dec (
      .bus_wr    (bus_wr),
      .bus_rd    (bus_rd),
      .bus_addr  (bus_addr),
      .bus_wdata (bus_wdata),
      .ctl       (ctl)
   );

   ringnet_flag_bank #(
      .PAGE_W     (PAGE_W),
      .NODE_RESET (NODE_RESET),
      .CFG_RESET  (CFG_RESET)
   ) u_flags (
      .clk          (clk),
      .rst_n        (rst_n),
      .ctl          (ctl),
      .tx_ack       (tx_ack),
      .tx_done      (tx_done),
      .rx_valid     (rx_valid),
      .rx_dest      (rx_dest),
      .diag_set     (diag_set),
      .status_q     (status_w),
      .mask_q       (mask_w),
      .cfg_q        (cfg_w),
      .node_q       (node_w),
      .diag_q       (diag_w),
      .bcast_q      (bcast_w),
      .quiet_q      (quiet_w),
      .seed_q       (seed_w),
      .tx_start_q   (tx_start),
      .tx_page_q    (tx_page),
      .tx_long_q    (tx_long),
      .rx_store_q   (rx_store),
      .store_page_q (rx_page)
   );

   ringnet_irq_edge #(.W(8)) u_irq (
      .clk   (clk),
      .rst_n (rst_n),
      .cause (status_w & mask_w & IRQ_SRC),
      .quiet (quiet_w),
      .irq   (irq)
   );

   assign rx_ready      = ~status_w[ST_RB];
   assign buf_init      = seed_w;
   assign buf_init_word = {node_w, MAGIC};

   always_comb begin
      bus_rdata = 8'h00;
      if ((bus_addr >> 4) == '0) begin
         unique case (bus_addr[3:0])
            OFF_STAT: bus_rdata = status_w;
            OFF_CMD:  bus_rdata = diag_w;
            OFF_CFG:  bus_rdata = cfg_w;
            OFF_NODE: bus_rdata = node_w;
            default:  bus_rdata = 8'h00;
         endcase
      end
   end
endmodule

// File: rtl/ringnet_ctrl_sva.sv
`timescale 1ns/1ps
module ringnet_ctrl_sva
   import ringnet_pkg::*;
#(
   parameter int ADDR_W = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bus_wr,
   input logic              bus_rd,
   input logic [ADDR_W-1:0] bus_addr,
   input logic [2:0]        cmd_op,
   input logic              tx_ack,
   input logic              tx_done,
   input logic              rx_valid,
   input logic [7:0]        rx_dest,
   input logic              rx_store,
   input logic [7:0]        diag_set,
   input logic [7:0]        status_w,
   input logic [7:0]        mask_w,
   input logic [7:0]        diag_w,
   input logic              bcast_w,
   input logic              buf_init,
   input logic              irq
);
   logic cmd_wr, rst_hit;
   assign cmd_wr  = bus_wr && bus_addr == ADDR_W'(1);
   assign rst_hit = (bus_wr || bus_rd) && bus_addr >= ADDR_W'(8) && bus_addr <= ADDR_W'(11);

   a_r10_irq_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> $past(|(status_w & mask_w & IRQ_SRC)));

   a_r8_block_rx_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_wr && cmd_op == 3'd2) |=> ##1 !irq);

   a_r3_tx_clears_flags: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_wr && cmd_op == 3'd3 && !tx_ack && !tx_done) |=> (!status_w[ST_TF] && !status_w[ST_TK]));

   a_r7_refuse_blocked: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_valid && status_w[ST_RB]) |=> !rx_store);

   a_r7_bcast_filter: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_valid && rx_dest == 8'h00 && !bcast_w) |=> !rx_store);

   a_r11_soft_reset: assert property (@(posedge clk) disable iff (!rst_n)
      rst_hit |=> (status_w == ST_RESET && mask_w == 8'h00 && buf_init));

   a_r12_diag_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd && bus_addr == ADDR_W'(1) && diag_set == 8'h00) |=> diag_w == 8'h00);
endmodule

bind ringnet_ctrl_core ringnet_ctrl_sva #(.ADDR_W(ADDR_W)) u_sva (
   .clk      (clk),
   .rst_n    (rst_n),
   .bus_wr   (bus_wr),
   .bus_rd   (bus_rd),
   .bus_addr (bus_addr),
   .cmd_op   (bus_wdata[2:0]),
   .tx_ack   (tx_ack),
   .tx_done  (tx_done),
   .rx_valid (rx_valid),
   .rx_dest  (rx_dest),
   .rx_store (rx_store),
   .diag_set (diag_set),
   .status_w (status_w),
   .mask_w   (mask_w),
   .diag_w   (diag_w),
   .bcast_w  (bcast_w),
   .buf_init (buf_init),
   .irq      (irq)
);

// File: tb/sim_ringnet_ctrl_core.sv
`timescale 1ns/1ps
module sim_ringnet_ctrl_core;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_wr = 1'b0, bus_rd = 1'b0;
   logic [3:0]  bus_addr = '0;
   logic [7:0]  bus_wdata = '0;
   logic [7:0]  bus_rdata;
   logic        tx_start, tx_long, rx_ready, rx_store, buf_init, irq;
   logic [1:0]  tx_page, rx_page;
   logic        tx_ack = 1'b0, tx_done = 1'b0, rx_valid = 1'b0;
   logic [7:0]  rx_dest = '0, diag_set = '0;
   logic [15:0] buf_init_word;

   int n_chk = 0, n_fail = 0, cyc = 0;
   int exp_irq[$];
   bit done = 1'b0;

   always #2.5 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   ringnet_ctrl_core #(.NODE_RESET(8'h3C)) u0 (.*);

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
      end
   endtask

   task automatic report();
      if (!done) begin
         done = 1'b1;
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   endtask

   // scoreboard monitor for interrupt pulses
   always @(negedge clk) begin
      if (rst_n && irq) begin
         if (exp_irq.size() == 0) chk(1'b0, "R10 unexpected irq", cyc, -1);
         else begin
            int e;
            e = exp_irq.pop_front();
            chk(e == cyc, "R10 irq cycle", cyc, e);
         end
      end
   end

   task automatic wr_reg(input logic [3:0] a, input logic [7:0] d, input bit irq_next);
      if (irq_next) exp_irq.push_back(cyc + 2);
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd_reg(input logic [3:0] a, output logic [7:0] v);
      bus_rd = 1'b1; bus_addr = a;
      #1 v = bus_rdata;
      @(negedge clk);
      bus_rd = 1'b0;
   endtask

   task automatic link_ev(input int kind, input logic [7:0] dest, input bit irq_next);
      if (irq_next) exp_irq.push_back(cyc + 2);
      case (kind)
         0: tx_ack = 1'b1;
         1: tx_done = 1'b1;
         default: begin rx_valid = 1'b1; rx_dest = dest; end
      endcase
      @(negedge clk);
      tx_ack = 1'b0; tx_done = 1'b0; rx_valid = 1'b0;
   endtask

   task automatic status_is(input logic [7:0] e, input string tag);
      logic [7:0] v;
      rd_reg(4'h0, v);
      chk(v == e, tag, v, e);
   endtask

   initial begin
      #(5.0 * 100000);
      chk(1'b0, "watchdog expired", cyc, 0);
      report();
   end

   initial begin
      logic [7:0] v;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1 seed pulse right after reset
      chk(buf_init == 1'b1 && buf_init_word == 16'h3CD1, "R1 buf_init after reset", buf_init_word, 16'h3CD1);
      chk(irq == 1'b0, "R1 irq idle", irq, 0);
      status_is(8'h95, "R1 status reset");
      chk(buf_init == 1'b0, "R1 buf_init single pulse", buf_init, 0);
      rd_reg(4'h2, v); chk(v == 8'h1C, "R1 setup reset", v, 8'h1C);
      rd_reg(4'h5, v); chk(v == 8'h3C, "R1 node reset", v, 8'h3C);
      rd_reg(4'h3, v); chk(v == 8'h00, "R2 unused offset reads 0", v, 0);
      rd_reg(4'hE, v); chk(v == 8'h00, "R2 high offset reads 0", v, 0);

      // R10 unmasking a set TF raises irq
      wr_reg(4'h0, 8'h01, 1'b1);
      // R3 start transmit from page 2
      wr_reg(4'h1, 8'h13, 1'b0);
      chk(tx_start && tx_page == 2'd2 && !tx_long, "R3 tx_start page2 short", {tx_start, tx_page, tx_long}, 4'b1100);
      status_is(8'h94, "R3 TF TK cleared");
      chk(!tx_start, "R3 tx_start single pulse", tx_start, 0);
      // R4 link events
      link_ev(0, 8'h00, 1'b0);
      status_is(8'h96, "R4 ack sets TK");
      link_ev(1, 8'h00, 1'b1);
      status_is(8'h97, "R4 done sets TF");
      // R5 long mode
      wr_reg(4'h1, 8'h0D, 1'b0);
      wr_reg(4'h1, 8'h0B, 1'b0);
      chk(tx_start && tx_page == 2'd1 && tx_long, "R5 long transmit page1", {tx_start, tx_page, tx_long}, 4'b1011);
      status_is(8'h94, "R3 flags cleared again");
      // R4 cancel sets TF
      wr_reg(4'h1, 8'h01, 1'b1);
      status_is(8'h95, "R4 cancel sets TF");

      // R10 unmask RB while set
      wr_reg(4'h0, 8'h81, 1'b1);
      // R6 arm receive page 3, no broadcast
      wr_reg(4'h1, 8'h1C, 1'b0);
      chk(rx_ready, "R6 rx_ready after arm", rx_ready, 1);
      status_is(8'h15, "R6 RB cleared");
      // R7 broadcast dropped
      link_ev(2, 8'h00, 1'b0);
      chk(!rx_store && rx_ready, "R7 broadcast dropped", {rx_store, rx_ready}, 2'b01);
      // R7 addressed frame accepted
      link_ev(2, 8'h05, 1'b1);
      chk(rx_store && rx_page == 2'd3, "R7 store page3", {rx_store, rx_page}, 3'b111);
      status_is(8'h95, "R7 RB set on accept");
      // R7 refused while blocked
      link_ev(2, 8'h05, 1'b0);
      chk(!rx_store, "R7 refused while blocked", rx_store, 0);
      // R6 broadcast accepted into page 1
      wr_reg(4'h1, 8'h8C, 1'b0);
      link_ev(2, 8'h00, 1'b1);
      chk(rx_store && rx_page == 2'd1, "R6 broadcast stored page1", {rx_store, rx_page}, 3'b101);
      // R8 block receive is silent
      wr_reg(4'h1, 8'h04, 1'b0);
      wr_reg(4'h1, 8'h02, 1'b0);
      status_is(8'h95, "R8 block sets RB");
      repeat (3) @(negedge clk);
      // R9 reserved opcodes and flag clears
      wr_reg(4'h1, 8'h00, 1'b0);
      wr_reg(4'h1, 8'h07, 1'b0);
      status_is(8'h95, "R9 opcodes 0 and 7 no effect");
      wr_reg(4'h1, 8'h0E, 1'b0);
      status_is(8'h85, "R9 clear PU");
      wr_reg(4'h1, 8'h16, 1'b0);
      status_is(8'h81, "R9 clear RC");
      // R12 diagnostics
      diag_set = 8'h30; @(negedge clk); diag_set = 8'h00;
      rd_reg(4'h1, v); chk(v == 8'h30, "R12 diag captured", v, 8'h30);
      rd_reg(4'h1, v); chk(v == 8'h00, "R12 diag cleared by read", v, 0);
      // R2 setup and node registers
      wr_reg(4'h2, 8'h80, 1'b0);
      rd_reg(4'h2, v); chk(v == 8'h80, "R2 setup write", v, 8'h80);
      wr_reg(4'h5, 8'h7E, 1'b0);
      rd_reg(4'h5, v); chk(v == 8'h7E, "R2 node write", v, 8'h7E);

      // R11 soft reset by write, with long mode set beforehand
      wr_reg(4'h1, 8'h0D, 1'b0);
      wr_reg(4'hA, 8'h55, 1'b0);
      chk(buf_init && buf_init_word == 16'h7ED1, "R11 seed after soft reset", buf_init_word, 16'h7ED1);
      status_is(8'h95, "R11 status restored");
      rd_reg(4'h2, v); chk(v == 8'h1C, "R11 setup restored", v, 8'h1C);
      wr_reg(4'h1, 8'h03, 1'b0);
      chk(tx_start && !tx_long, "R11 long mode cleared", tx_long, 0);
      link_ev(1, 8'h00, 1'b0);   // mask cleared: no irq expected
      repeat (3) @(negedge clk);
      // R11 soft reset by read
      wr_reg(4'h1, 8'h0E, 1'b0);
      status_is(8'h85, "R11 PU cleared before read reset");
      rd_reg(4'h8, v); chk(v == 8'h00, "R11 reset offset reads 0", v, 0);
      status_is(8'h95, "R11 read access resets");

      repeat (4) @(negedge clk);
      chk(exp_irq.size() == 0, "R10 all expected irq seen", exp_irq.size(), 0);
      report();
   end
endmodule